// File: doc/BRIEF.md
# Ring-Buffer FIR Filter with Output Clamp

This block is a streaming finite-impulse-response filter that keeps the most recent `TAPS` input samples in a ring of registers. Each accepted sample overwrites the slot at the write pointer, and the pointer then advances, wrapping from the last slot back to slot 0. Once a sample is accepted, the block computes one output using a single multiplier, one tap per clock cycle. The read index starts at the write pointer, which after the write points at the oldest sample, and wraps the same way. The coefficient index counts up from 0. Coefficient 0 therefore weights the oldest sample and coefficient `TAPS-1` weights the newest.

After exactly `TAPS` multiply-accumulate steps, the sum is limited to the symmetric range `[-LIMIT, +LIMIT]`. It is then shown for one cycle with a valid pulse. The default `LIMIT` is 25600, which is 100 in a format with 8 fractional bits. Coefficients are written through an address/data port, and only while the filter is idle. A new sample is taken only while idle. The upstream side sees this through `smp_ready`.

The controller has three states. `ST_IDLE` waits for a sample; the transition *accept* (`smp_valid && smp_ready`) leads to `ST_STEP`. `ST_STEP` performs one tap per cycle and stays there until the *last tap* transition (coefficient index equal to `TAPS-1`) leads to `ST_EMIT`. `ST_EMIT` drives the result for one cycle and always takes the *return* transition back to `ST_IDLE`.

Top module: `ring_fir_clamp`

## Requirements
- R1: After reset `smp_ready` is 1, `res_valid` is 0, every ring slot and every coefficient hold 0, and the write pointer is at slot 0.
- R2: A sample is taken only on a cycle with `smp_valid` and `smp_ready` both 1. `smp_ready` is 0 from the cycle after that acceptance until the result pulse has ended. A `smp_valid` raised while busy is ignored.
- R3: The result equals the sum over j = 0..TAPS-1 of coef[j] times the sample accepted TAPS-1-j acceptances ago. Slots never written since reset count as 0, and the write pointer wraps from slot TAPS-1 to slot 0.
- R4: `res_valid` rises exactly TAPS+1 clock cycles after the accepting edge and stays high for one cycle. `smp_ready` is 1 on the cycle after the pulse.
- R5: A sum above +LIMIT is output as exactly +LIMIT. This includes full-scale inputs, whose sum must not wrap around.
- R6: A sum below -LIMIT is output as exactly -LIMIT.
- R7: A sum within [-LIMIT, +LIMIT], including both ends, is output unchanged, sign-extended to the result width.
- R8: A coefficient write (`cw_en`, `cw_addr` selecting coefficient index, `cw_data` signed) takes effect when made in idle. A write made while the filter is busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Filter idle and able to take a sample |
| smp_data | input | DW | Signed input sample |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | IW | Coefficient index to write |
| cw_data | input | DW | Signed coefficient value |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | ACC_W | Clamped signed result |

## Verification
The main function is driven with an asymmetric coefficient set over a run of ten samples. The first four results expose zero-filled slots after reset and the oldest-to-newest weighting. The later ones cross the pointer wrap, so a wrong start index or wrap rule gives a different sum. The same run mixes in-range sums with sums past both limits, and the sign and size of each distinguish a missing clamp from a wrong one. A single-tap coefficient set then places samples at +LIMIT, -LIMIT and one step beyond each, to pin the clamp boundary. Full-scale negative samples and coefficients test for accumulator overflow, and writes and samples offered mid-computation test that both are dropped.

// File: rtl/ring_fir_pkg.sv
package ring_fir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_EMIT = 2'd2
    } fir_state_t;

endpackage

// File: rtl/ring_store.sv
module ring_store #(
    parameter int TAPS = 4,
    parameter int DW   = 16,
    parameter int IW   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic signed [DW-1:0] wr_data,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [DW-1:0] rd_data,
    output logic [IW-1:0]        head
);
    localparam logic [IW-1:0] LAST = IW'(TAPS - 1);

    logic signed [DW-1:0] slot [TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (wr_en && head == IW'(g)) begin
                slot[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= '0;
        end else if (wr_en) begin
            head <= (head == LAST) ? '0 : head + IW'(1);
        end
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
    parameter int TAPS = 4,
    parameter int DW   = 16,
    parameter int IW   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IW-1:0]        wr_addr,
    input  logic signed [DW-1:0] wr_data,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [DW-1:0] rd_data
);
    logic signed [DW-1:0] coef [TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_coef
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                coef[g] <= '0;
            end else if (we && wr_addr == IW'(g)) begin
                coef[g] <= wr_data;
            end
        end
    end

    assign rd_data = coef[rd_idx];

endmodule

// File: rtl/mac_clamp.sv
module mac_clamp #(
    parameter int DW    = 16,
    parameter int ACC_W = 35,
    parameter int LIMIT = 25600
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    step,
    input  logic signed [DW-1:0]    op_a,
    input  logic signed [DW-1:0]    op_b,
    output logic signed [ACC_W-1:0] sum_sat
);
    localparam int PW = 2 * DW;
    localparam logic signed [ACC_W-1:0] LIM_P = ACC_W'(LIMIT);
    localparam logic signed [ACC_W-1:0] LIM_N = -LIM_P;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] acc;

    assign prod     = op_a * op_b;
    assign prod_ext = {{(ACC_W - PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (step) begin
            acc <= acc + prod_ext;
        end
    end

    always_comb begin
        if (acc > LIM_P) begin
            sum_sat = LIM_P;
        end else if (acc < LIM_N) begin
            sum_sat = LIM_N;
        end else begin
            sum_sat = acc;
        end
    end

endmodule

// File: rtl/ring_fir_clamp.sv
module ring_fir_clamp #(
    parameter int TAPS  = 4,
    parameter int DW    = 16,
    parameter int LIMIT = 25600,
    localparam int IW    = (TAPS > 1) ? $clog2(TAPS) : 1,
    localparam int ACC_W = 2 * DW + $clog2(TAPS) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    output logic                    smp_ready,
    input  logic signed [DW-1:0]    smp_data,
    input  logic                    cw_en,
    input  logic [IW-1:0]           cw_addr,
    input  logic signed [DW-1:0]    cw_data,
    output logic                    res_valid,
    output logic signed [ACC_W-1:0] res_data
);
    import ring_fir_pkg::*;

    localparam logic [IW-1:0] LAST = IW'(TAPS - 1);

    fir_state_t state, state_nx;
    logic [IW-1:0]        rd_ptr;
    logic [IW-1:0]        tap_idx;
    logic [IW-1:0]        head;
    logic                 take;
    logic                 coef_we;
    logic                 mac_step;
    logic signed [DW-1:0] smp_rd;
    logic signed [DW-1:0] coef_rd;
    logic signed [ACC_W-1:0] sum_sat;

    assign take     = (state == ST_IDLE) && smp_valid;
    assign coef_we  = (state == ST_IDLE) && cw_en;
    assign mac_step = (state == ST_STEP);

    ring_store #(.TAPS(TAPS), .DW(DW), .IW(IW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take),
        .wr_data (smp_data),
        .rd_idx  (rd_ptr),
        .rd_data (smp_rd),
        .head    (head)
    );

    coef_bank #(.TAPS(TAPS), .DW(DW), .IW(IW)) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (coef_we),
        .wr_addr (cw_addr),
        .wr_data (cw_data),
        .rd_idx  (tap_idx),
        .rd_data (coef_rd)
    );

    mac_clamp #(.DW(DW), .ACC_W(ACC_W), .LIMIT(LIMIT)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (take),
        .step    (mac_step),
        .op_a    (coef_rd),
        .op_b    (smp_rd),
        .sum_sat (sum_sat)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (smp_valid)       state_nx = ST_STEP;  // accept
            ST_STEP: if (tap_idx == LAST) state_nx = ST_EMIT;  // last tap
            ST_EMIT:                      state_nx = ST_IDLE;  // return
            default:                      state_nx = ST_IDLE;
        endcase
    end

    // state register and walking indices
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rd_ptr  <= '0;
            tap_idx <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                rd_ptr  <= (head == LAST) ? '0 : head + IW'(1);
                tap_idx <= '0;
            end else if (mac_step) begin
                rd_ptr  <= (rd_ptr == LAST) ? '0 : rd_ptr + IW'(1);
                tap_idx <= tap_idx + IW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        smp_ready = 1'b0;
        res_valid = 1'b0;
        res_data  = '0;
        unique case (state)
            ST_IDLE: smp_ready = 1'b1;
            ST_STEP: ;
            ST_EMIT: begin
                res_valid = 1'b1;
                res_data  = sum_sat;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ring_fir_clamp_chk.sv
module ring_fir_clamp_chk #(
    parameter int ACC_W = 35,
    parameter int LIMIT = 25600
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_valid,
    input logic                    smp_ready,
    input logic                    res_valid,
    input logic signed [ACC_W-1:0] res_data
);
    localparam logic signed [ACC_W-1:0] LP = ACC_W'(LIMIT);
    localparam logic signed [ACC_W-1:0] LN = -LP;

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);  // R2
    AST_BUSY_DURING_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !smp_ready);  // R2
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);  // R4
    AST_READY_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> smp_ready);  // R4
    AST_UPPER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_data <= LP));  // R5
    AST_LOWER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_data >= LN));  // R6

endmodule

bind ring_fir_clamp ring_fir_clamp_chk #(.ACC_W(ACC_W), .LIMIT(LIMIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/ring_fir_clamp_test.sv
module ring_fir_clamp_test;
    localparam int TAPS  = 4;
    localparam int DW    = 16;
    localparam int LIMIT = 25600;
    localparam int IW    = 2;
    localparam int ACC_W = 2 * DW + $clog2(TAPS) + 1;

    typedef struct packed {
        logic signed [15:0] x;
        logic signed [31:0] y;
    } vec_t;

    // coefficients 1,2,3,4; expected values follow R3, R5, R6, R7
    localparam vec_t VEC [10] = '{
        '{16'sd100,    32'sd400},
        '{-16'sd50,    32'sd100},
        '{16'sd10,     32'sd90},
        '{16'sd7,      32'sd58},
        '{16'sd1000,   32'sd3991},
        '{16'sd8000,   32'sd25600},
        '{-16'sd9000,  -32'sd9993},
        '{-16'sd20000, -32'sd25600},
        '{16'sd0,      -32'sd25600},
        '{16'sd6400,   -32'sd23400}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    smp_valid = 1'b0;
    logic                    smp_ready;
    logic signed [DW-1:0]    smp_data = '0;
    logic                    cw_en = 1'b0;
    logic [IW-1:0]           cw_addr = '0;
    logic signed [DW-1:0]    cw_data = '0;
    logic                    res_valid;
    logic signed [ACC_W-1:0] res_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ring_fir_clamp #(.TAPS(TAPS), .DW(DW), .LIMIT(LIMIT)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .smp_data  (smp_data),
        .cw_en     (cw_en),
        .cw_addr   (cw_addr),
        .cw_data   (cw_data),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_coef(input int idx, input int val);
        @(negedge clk);
        cw_en   = 1'b1;
        cw_addr = IW'(idx);
        cw_data = DW'(val);
        @(negedge clk);
        cw_en   = 1'b0;
    endtask

    // offer one sample; optionally poke a coef write and a sample while busy
    task automatic run_one(input int x, input bit poke, output longint y);
        int cnt;
        @(negedge clk);
        chk("R2 ready before accept", smp_ready == 1'b1, smp_ready, 1);
        smp_valid = 1'b1;
        smp_data  = DW'(x);
        @(negedge clk);
        smp_valid = 1'b0;
        cnt = 1;
        chk("R2 busy after accept", smp_ready == 1'b0, smp_ready, 0);
        if (poke) begin
            cw_en     = 1'b1;
            cw_addr   = IW'(3);
            cw_data   = DW'(5);
            smp_valid = 1'b1;
            smp_data  = DW'(999);
            @(negedge clk);
            cnt++;
            cw_en     = 1'b0;
            smp_valid = 1'b0;
        end
        while (!res_valid && cnt < 50) begin
            @(negedge clk);
            cnt++;
        end
        chk("R4 result latency", cnt == TAPS + 1, cnt, TAPS + 1);
        y = longint'(res_data);
        @(negedge clk);
        chk("R4 one-cycle pulse", res_valid == 1'b0, res_valid, 0);
        chk("R4 ready after pulse", smp_ready == 1'b1, smp_ready, 1);
    endtask

    initial begin
        longint y;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", smp_ready == 1'b1, smp_ready, 1);
        chk("R1 reset valid", res_valid == 1'b0, res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", smp_ready == 1'b1 && res_valid == 1'b0, smp_ready, 1);

        // R8 idle writes take effect; R3 ordering
        for (int k = 0; k < TAPS; k++) wr_coef(k, k + 1);
        for (int i = 0; i < 10; i++) begin
            run_one(int'(VEC[i].x), 1'b0, y);
            chk($sformatf("R3 R5 R6 R7 vector %0d", i), y == longint'(VEC[i].y), y, longint'(VEC[i].y));
        end

        // boundary tests: only the newest sample counts
        for (int k = 0; k < TAPS - 1; k++) wr_coef(k, 0);
        wr_coef(3, 1);
        run_one(25600, 1'b0, y);
        chk("R7 at +LIMIT", y == 25600, y, 25600);
        run_one(-25600, 1'b0, y);
        chk("R7 at -LIMIT", y == -25600, y, -25600);
        run_one(25601, 1'b0, y);
        chk("R5 just above", y == 25600, y, 25600);
        run_one(-25601, 1'b0, y);
        chk("R6 just below", y == -25600, y, -25600);
        run_one(-1234, 1'b0, y);
        chk("R7 negative passes", y == -1234, y, -1234);

        // R8 and R2: write and sample offered while busy are dropped
        run_one(300, 1'b1, y);
        chk("R8 busy write no effect on current", y == 300, y, 300);
        run_one(-7, 1'b0, y);
        chk("R8 busy write dropped", y == -7, y, -7);
        chk("R2 busy sample dropped", y == -7, y, -7);

        // R5 full-scale: no wrap of the accumulator
        for (int k = 0; k < TAPS; k++) wr_coef(k, -32768);
        for (int i = 0; i < TAPS; i++) run_one(-32768, 1'b0, y);
        chk("R5 full scale clamps", y == 25600, y, 25600);
        for (int k = 0; k < TAPS; k++) wr_coef(k, 32767);
        run_one(-32768, 1'b0, y);
        chk("R6 full scale clamps", y == -25600, y, -25600);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk("watchdog", 1'b0, 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule